// File: doc/BRIEF.md
# Masked Cache-Line Coherence Updater

This block writes one incoming coherence update into one line of a cache data array. The update is a line-sized buffer of data words, and each word has its own byte-enable field. After a start pulse that names the set and the way, the block walks the line in ascending word order. For each word it reads the old value from the single-port data array. In the next cycle it writes back the old value with the enabled bytes replaced by the new ones. When the walk is over it raises a one-cycle done pulse.

A skip mode is chosen for each update by a pin that is sampled together with start. In that mode, words whose byte-enable field is all zero cause no array access at all. A lookahead over the byte enables jumps straight to the next word that needs work, so a skipped word costs no cycles. While `busy` is high the block owns the data array, and the surrounding cache pipeline must keep off it. The requester keeps the update buffer and the line selection stable until `busy` falls. The data-array port is a plain memory port rather than a stream: it has an enable, a write strobe and a read result that arrives one cycle after the read. The block therefore applies no back-pressure on it. The line is held in flat input vectors, so there is no streaming edge. `WORDS`, `SETS` and `WAYS` must be powers of two, and `WORDS` must be at least 2.

Top module: `lineupd_top`

## Requirements
- R1: After reset, `busy`, `done` and `arr_en` are low, and no array access happens until a start pulse is accepted.
- R2: Each processed word takes exactly two consecutive array cycles: a read (`arr_en`=1, `arr_we`=0) followed by a write (`arr_en`=1, `arr_we`=1) to the same address. The read result is expected on `arr_rdata` during the write cycle.
- R3: The written word is byte-wise merged: byte i (bits 8i+7..8i) takes the new byte when byte-enable bit i of that word is 1, and keeps the old byte otherwise. Word k of the buffer is `line_data[32k+31:32k]`, and its enables are `line_be[4k+3:4k]`.
- R4: With `skip_en`=0 at start, every word of the line is read and written in ascending order, including words with an all-zero mask. `busy` is high for 2×WORDS+1 cycles.
- R5: With `skip_en`=1 at start, only words with a nonzero byte-enable field are read and written, in ascending order. `busy` is high for 2×N+1 cycles, where N is the number of such words.
- R6: With `skip_en`=1 and every byte enable zero, the array is never touched and `done` rises in the cycle right after the start is accepted.
- R7: `done` is high for exactly one cycle, in the cycle after the last write (the last cycle of `busy`). The array is idle during that cycle, and `busy` is low in the cycle after it.
- R8: A start pulse while `busy` is high is ignored: the set, way and mode of the running update do not change, and no second update follows.
- R9: `arr_addr` is {set, way, word} with the word index in the low log2(WORDS) bits, and writes reach only the line named at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only when not busy |
| start_set | input | SETW | Set index of the target line |
| start_way | input | WAYW | Way index of the target line |
| skip_en | input | 1 | Skip words with all-zero byte enables (sampled with start) |
| line_data | input | WORDS*32 | Update buffer data, word k at bits 32k+31..32k |
| line_be | input | WORDS*4 | Update buffer byte enables, word k at bits 4k+3..4k |
| busy | output | 1 | Update in progress, array owned by the block |
| done | output | 1 | One-cycle completion pulse |
| arr_en | output | 1 | Data array access enable |
| arr_we | output | 1 | Data array write strobe |
| arr_addr | output | SETW+WAYW+WORDW | Data array word address {set, way, word} |
| arr_wdata | output | 32 | Merged write data |
| arr_rdata | input | 32 | Array read data, valid one cycle after a read |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a running update with a different set. Any leak would show as writes to a second line or as a longer busy window. The bench raises start with another set for several cycles inside a run. It then compares the whole modelled array against a shadow copy and checks the busy length. The skip-mode edge cases, where only the first word or only the last word has enables and where no word has any, are also driven directly. They show that the lookahead neither runs past the end of the line nor touches words it should skip.

// File: rtl/lineupd_pkg.sv
package lineupd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } upd_state_t;
endpackage

// File: rtl/lineupd_pick.sv
// Finds the lowest word index >= from_idx that needs work.
module lineupd_pick #(
  parameter int WORDS = 8,
  parameter int BEW   = 4,
  localparam int WORDW = $clog2(WORDS)
) (
  input  logic [WORDS*BEW-1:0] be_flat,
  input  logic [WORDW:0]       from_idx,
  input  logic                 skip,
  output logic                 found,
  output logic [WORDW-1:0]     idx
);
  logic [WORDS-1:0] cand;

  for (genvar g = 0; g < WORDS; g++) begin : g_cand
    assign cand[g] = ((WORDW+1)'(g) >= from_idx) &&
                     (!skip || (|be_flat[g*BEW +: BEW]));
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = WORDW'(i);
      end
    end
  end
endmodule

// File: rtl/lineupd_merge.sv
// Byte-wise merge of new data into old data under a byte mask.
module lineupd_merge #(
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input  logic [DW-1:0]  old_word,
  input  logic [DW-1:0]  new_word,
  input  logic [BEW-1:0] mask,
  output logic [DW-1:0]  merged
);
  for (genvar b = 0; b < BEW; b++) begin : g_byte
    assign merged[b*8 +: 8] = mask[b] ? new_word[b*8 +: 8] : old_word[b*8 +: 8];
  end
endmodule

// File: rtl/lineupd_top.sv
module lineupd_top #(
  parameter int WORDS = 8,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int DW    = 32,
  localparam int WORDW = $clog2(WORDS),
  localparam int SETW  = $clog2(SETS),
  localparam int WAYW  = $clog2(WAYS),
  localparam int BEW   = DW / 8,
  localparam int AW    = SETW + WAYW + WORDW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SETW-1:0]      start_set,
  input  logic [WAYW-1:0]      start_way,
  input  logic                 skip_en,
  input  logic [WORDS*DW-1:0]  line_data,
  input  logic [WORDS*BEW-1:0] line_be,
  output logic                 busy,
  output logic                 done,
  output logic                 arr_en,
  output logic                 arr_we,
  output logic [AW-1:0]        arr_addr,
  output logic [DW-1:0]        arr_wdata,
  input  logic [DW-1:0]        arr_rdata
);
  import lineupd_pkg::*;

  upd_state_t       state_q;
  logic [SETW-1:0]  set_q;
  logic [WAYW-1:0]  way_q;
  logic             skip_q;
  logic [WORDW-1:0] word_q;

  logic             idle;
  logic [WORDW:0]   from_idx;
  logic             pick_skip;
  logic             pick_found;
  logic [WORDW-1:0] pick_idx;

  assign idle      = (state_q == ST_IDLE);
  assign from_idx  = idle ? '0 : ({1'b0, word_q} + 1'b1);
  assign pick_skip = idle ? skip_en : skip_q;

  lineupd_pick #(.WORDS(WORDS), .BEW(BEW)) pick_i (
    .be_flat  (line_be),
    .from_idx (from_idx),
    .skip     (pick_skip),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      set_q   <= '0;
      way_q   <= '0;
      skip_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            set_q  <= start_set;
            way_q  <= start_way;
            skip_q <= skip_en;
            word_q <= pick_idx;
            state_q <= pick_found ? ST_RD : ST_DONE;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (pick_found) begin
            word_q  <= pick_idx;
            state_q <= ST_RD;
          end else begin
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = !idle;
  assign done     = (state_q == ST_DONE);
  assign arr_en   = (state_q == ST_RD) || (state_q == ST_WR);
  assign arr_we   = (state_q == ST_WR);
  assign arr_addr = {set_q, way_q, word_q};

  lineupd_merge #(.DW(DW)) merge_i (
    .old_word (arr_rdata),
    .new_word (line_data[word_q*DW +: DW]),
    .mask     (line_be[word_q*BEW +: BEW]),
    .merged   (arr_wdata)
  );
endmodule

// File: rtl/lineupd_chk.sv
module lineupd_chk #(
  parameter int AW    = 9,
  parameter int WORDW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          arr_en,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr
);
  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_en && !arr_we) |=> (arr_en && arr_we && arr_addr == $past(arr_addr)));

  // R2
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_en && arr_we) |-> $past(arr_en && !arr_we));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!arr_en && busy));

  // R1
  access_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |-> busy);

  // R8
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_en && $past(arr_en)) |-> (arr_addr[AW-1:WORDW] == $past(arr_addr[AW-1:WORDW])));
endmodule

bind lineupd_top lineupd_chk #(.AW(AW), .WORDW(WORDW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .arr_en   (arr_en),
  .arr_we   (arr_we),
  .arr_addr (arr_addr)
);

// File: tb/lineupd_top_tb_top.sv
module lineupd_top_tb_top;
  localparam int WORDS = 8;
  localparam int SETS  = 16;
  localparam int WAYS  = 4;
  localparam int DW    = 32;
  localparam int DEPTH = WORDS * SETS * WAYS;
  localparam int NVEC  = 6;

  // {set[4], way[2], skip[1], be[32], seed[32]}
  localparam logic [70:0] VEC [NVEC] = '{
    {4'd3,  2'd1, 1'b0, 32'hFFFF_FFFF, 32'h1111_1111},
    {4'd3,  2'd1, 1'b0, 32'h1200_F0A5, 32'hDEAD_BEEF},
    {4'd0,  2'd0, 1'b1, 32'h0F00_00C1, 32'h0BAD_F00D},
    {4'd15, 2'd3, 1'b1, 32'h8000_0000, 32'hCAFE_0001},
    {4'd15, 2'd3, 1'b1, 32'h0000_0001, 32'h7777_8888},
    {4'd7,  2'd2, 1'b0, 32'h0000_0000, 32'h5555_AAAA}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [3:0]        start_set = '0;
  logic [1:0]        start_way = '0;
  logic              skip_en = 1'b0;
  logic [WORDS*DW-1:0] line_data = '0;
  logic [WORDS*4-1:0]  line_be = '0;
  logic              busy, done, arr_en, arr_we;
  logic [8:0]        arr_addr;
  logic [DW-1:0]     arr_wdata;
  logic [DW-1:0]     arr_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lineupd_top #(.WORDS(WORDS), .SETS(SETS), .WAYS(WAYS), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_set(start_set),
    .start_way(start_way), .skip_en(skip_en), .line_data(line_data),
    .line_be(line_be), .busy(busy), .done(done), .arr_en(arr_en),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata)
  );

  // array model and access monitor
  logic [DW-1:0] mem     [DEPTH];
  logic [DW-1:0] exp_mem [DEPTH];
  int rd_cnt, wr_cnt, order_bad, line_bad, last_word, any_access;
  logic [5:0] exp_line;

  function automatic logic [DW-1:0] init_val(int a);
    return 32'h9E37_79B1 * a + 32'h0000_0007;
  endfunction

  always @(posedge clk) begin
    if (arr_en) begin
      any_access <= any_access + 1;
      if (arr_we) begin
        mem[arr_addr] <= arr_wdata;
        wr_cnt <= wr_cnt + 1;
        if (int'(arr_addr[2:0]) <= last_word) order_bad <= order_bad + 1;
        last_word <= int'(arr_addr[2:0]);
        if (arr_addr[8:3] != exp_line) line_bad <= line_bad + 1;
      end else begin
        arr_rdata <= mem[arr_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic run_upd(input logic [3:0] set, input logic [1:0] way,
                         input logic skip, input logic [31:0] be,
                         input logic [31:0] seed, input bit inject,
                         input string req);
    int n = 0;
    int busy_cyc = 0;
    int done_cyc = 0;
    int bad = 0;
    logic [DW-1:0] nw;
    // expected result from the merge rule (R3) and address format (R9)
    for (int k = 0; k < WORDS; k++) begin
      int a = {set, way, k[2:0]};
      nw = seed + 32'h0103_0507 * k;
      if (!skip || be[4*k +: 4] != 4'h0) n++;
      for (int b = 0; b < 4; b++)
        if (be[4*k+b]) exp_mem[a][8*b +: 8] = nw[8*b +: 8];
    end
    @(negedge clk);
    for (int k = 0; k < WORDS; k++)
      line_data[32*k +: 32] = seed + 32'h0103_0507 * k;
    line_be = be; start_set = set; start_way = way; skip_en = skip;
    exp_line = {set, way};
    rd_cnt = 0; wr_cnt = 0; order_bad = 0; line_bad = 0; last_word = -1; any_access = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int it = 0; it < 100; it++) begin
      if (inject && it == 1) begin
        start = 1'b1; start_set = set ^ 4'd1; skip_en = ~skip;  // R8 stimulus
      end
      if (inject && it == 4) start = 1'b0;
      if (busy) busy_cyc++;
      if (done) done_cyc++;
      if (!busy) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy_cyc == 2*n+1, req, "busy cycles", busy_cyc, 2*n+1);
    chk(done_cyc == 1, "R7", "done cycles", done_cyc, 1);
    chk(rd_cnt == n && wr_cnt == n, "R2", "reads/writes", rd_cnt*256+wr_cnt, n*256+n);
    chk(order_bad == 0, req, "ascending order violations", order_bad, 0);
    chk(line_bad == 0, "R9", "writes outside line", line_bad, 0);
    for (int a = 0; a < DEPTH; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, "R3", "mismatching array words", bad, 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(!busy && any_access == 2*n, "R8", "extra activity after ignored start",
          any_access, 2*n);
    end
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      mem[a] = init_val(a);
      exp_mem[a] = init_val(a);
    end
    arr_rdata = '0;
    rd_cnt = 0; wr_cnt = 0; order_bad = 0; line_bad = 0; last_word = -1; any_access = 0;
    exp_line = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !arr_en, "R1", "outputs in reset", {busy, done, arr_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && any_access == 0, "R1", "idle after reset",
        {busy, done, 1'b0} + any_access, 0);

    // table-driven updates (R4 for skip off, R5 for skip on)
    for (int v = 0; v < NVEC; v++) begin
      logic [70:0] e = VEC[v];
      run_upd(e[70:67], e[66:65], e[64], e[63:32], e[31:0], 1'b0,
              e[64] ? "R5" : "R4");
    end

    // R6: skip mode with an empty mask, done right after accept
    @(negedge clk);
    line_be = '0; skip_en = 1'b1; start_set = 4'd9; start_way = 2'd0;
    any_access = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && done, "R6", "done in cycle after start", {busy, done}, 2'b11);
    @(negedge clk);
    chk(!busy && !done && any_access == 0, "R6", "no access on empty line",
        any_access, 0);

    // R8: start with another set and mode while busy
    run_upd(4'd5, 2'd2, 1'b0, 32'h3C00_0F11, 32'h2468_ACE0, 1'b1, "R8");

    summary();
    $finish;
  end
endmodule